// File: doc/BRIEF.md
# Programmable Watchdog Timer

This block supervises a processor by counting 1 ms tick-enable pulses from a slow, independent time base. Software arms it through a small control register, picks one of eight power-of-two timeout lengths, and must keep restarting the count before it reaches the chosen limit. If the limit is reached first, the block drives a reset pulse of fixed length toward the CPU. It then returns its control register to the state it has after power-on, so the watchdog is disarmed again.

The control word is five bits wide. Bit 0 arms the watchdog. Bit 1 restarts the count. Bits 4:2 hold the period select. A power-down input holds the watchdog off for as long as it is asserted. The count can be read at any time, for diagnostics.

Top module: `wdog_timer`

## Requirements
- R1: While reset is asserted, and after it is released, the control readback is 0, the count is 0 and the CPU reset output is low. An asserted reset clears the outputs at once, without waiting for a clock.
- R2: The control word has enable at bit 0, restart at bit 1 and period select S at bits 4:2. The timeout period is 16 << S ticks, so S=0 gives 16 and S=7 gives 2048.
- R3: While enable is 0, the count stays at 0, ticks are ignored and no reset pulse is produced. A write that clears enable also clears the count.
- R4: A write with the restart bit set clears the count, so that a full new period begins. The restart bit always reads back as 0.
- R5: A write that changes the period select clears the count. A write that keeps the same select and enable, with no restart, leaves the count unchanged.
- R6: While power-down is high, enable is forced to 0, the count is held at 0 and control writes are ignored.
- R7: The period-th tick counted while enabled raises the CPU reset output on the following clock. The output stays high for exactly 4 clocks. Control writes made during the pulse are ignored.
- R8: When the reset pulse ends, enable and period select both read back as 0.
- R9: While enabled, the count rises by one on each clock that has the tick input high, and holds on clocks without a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | 1 ms time-base enable, one clock wide |
| pwr_down_i | input | 1 | Power-down; holds the watchdog off |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 5 | Control write data: bit 0 enable, bit 1 restart, bits 4:2 select |
| cfg_rdata_o | output | 5 | Control readback; the restart bit reads 0 |
| cnt_o | output | 12 | Current tick count |
| cpu_rst_o | output | 1 | Active-high reset pulse to the CPU |

## Verification
The bench uses the default parameters: a 16-tick base, a 3-bit select and a 4-clock pulse. It drives the tick input on every clock, so even the 2048-tick setting finishes in a few thousand clocks. The table walks the selects 0, 1, 4 and 7, which covers both ends of the range. Directed tests then cover restart, select changes, disabling, power-down and writes made during the pulse, each at its exact cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int EN_BIT      = 0;
  localparam int RESTART_BIT = 1;
  localparam int SEL_LSB     = 2;
endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/wdog_period_dec.sv
module wdog_period_dec #(
  parameter int SEL_W     = 3,
  parameter int BASE_LOG2 = 4,
  parameter int CNT_W     = BASE_LOG2 + (1 << SEL_W)
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [CNT_W-1:0] last_o
);
  localparam int NUM_SEL = 1 << SEL_W;

  logic [CNT_W-1:0] last_tbl [NUM_SEL];

  // one entry per select value: terminal count = period - 1
  for (genvar g = 0; g < NUM_SEL; g++) begin : g_tbl
    assign last_tbl[g] = CNT_W'((64'd1 << (BASE_LOG2 + g)) - 64'd1);
  end

  assign last_o = last_tbl[sel_i];
endmodule

// File: rtl/wdog_pulse_gen.sv
module wdog_pulse_gen #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic active_o,
  output logic done_o
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] len_q, len_d;
  logic          len_ce;

  always_comb begin
    len_d = len_q;
    if (fire_i)             len_d = PW'(PULSE_LEN);
    else if (len_q != '0)   len_d = len_q - PW'(1);
  end

  assign len_ce = fire_i || (len_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (len_ce) len_q <= len_d;
  end

  assign active_o = (len_q != '0);
  assign done_o   = (len_q == PW'(1));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int SEL_W     = 3,
  parameter int BASE_LOG2 = 4,
  parameter int PULSE_LEN = 4,
  parameter int CTRL_W    = wdog_pkg::SEL_LSB + SEL_W,
  parameter int CNT_W     = BASE_LOG2 + (1 << SEL_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              pwr_down_i,
  input  logic              cfg_we_i,
  input  logic [CTRL_W-1:0] cfg_wdata_i,
  output logic [CTRL_W-1:0] cfg_rdata_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              cpu_rst_o
);
  import wdog_pkg::*;

  logic             rst_n_s;
  logic             en_q, en_d;
  logic [SEL_W-1:0] sel_q, sel_d, wsel;
  logic [CNT_W-1:0] cnt_q, cnt_d, last;
  logic             fire, clr, ctrl_ce, cnt_ce;
  logic             pulse_active, pulse_done;

  wdog_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  wdog_period_dec #(
    .SEL_W     (SEL_W),
    .BASE_LOG2 (BASE_LOG2),
    .CNT_W     (CNT_W)
  ) u_period (
    .sel_i  (sel_q),
    .last_o (last)
  );

  wdog_pulse_gen #(
    .PULSE_LEN (PULSE_LEN)
  ) u_pulse (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .fire_i   (fire),
    .active_o (pulse_active),
    .done_o   (pulse_done)
  );

  assign wsel = cfg_wdata_i[SEL_LSB +: SEL_W];

  // next-state: power-down > pulse in progress > write > tick
  always_comb begin
    en_d  = en_q;
    sel_d = sel_q;
    cnt_d = cnt_q;
    fire  = 1'b0;
    clr   = 1'b0;
    if (pwr_down_i) begin
      en_d  = 1'b0;
      cnt_d = '0;
    end else if (pulse_active) begin
      cnt_d = '0;
    end else begin
      if (cfg_we_i) begin
        en_d  = cfg_wdata_i[EN_BIT];
        sel_d = wsel;
        clr   = cfg_wdata_i[RESTART_BIT] || (wsel != sel_q) || !cfg_wdata_i[EN_BIT];
      end
      if (clr || !en_d) begin
        cnt_d = '0;
      end else if (tick_i) begin
        if (cnt_q == last) begin
          fire  = 1'b1;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
    end
    // end of the CPU reset pulse returns control to its reset state
    if (pulse_done) begin
      en_d  = 1'b0;
      sel_d = '0;
    end
  end

  assign ctrl_ce = pwr_down_i || pulse_done || (cfg_we_i && !pulse_active);
  assign cnt_ce  = (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      en_q  <= 1'b0;
      sel_q <= '0;
    end else if (ctrl_ce) begin
      en_q  <= en_d;
      sel_q <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  always_comb begin
    cfg_rdata_o                     = '0;
    cfg_rdata_o[EN_BIT]             = en_q;
    cfg_rdata_o[SEL_LSB +: SEL_W]   = sel_q;
  end

  assign cnt_o     = cnt_q;
  assign cpu_rst_o = pulse_active;
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int SEL_W     = 3,
  parameter int BASE_LOG2 = 4,
  parameter int PULSE_LEN = 4,
  parameter int CNT_W     = BASE_LOG2 + (1 << SEL_W)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             pwr_down_i,
  input logic             cfg_we_i,
  input logic             restart_wr_i,
  input logic             en_rd_i,
  input logic [SEL_W-1:0] sel_rd_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             cpu_rst_o
);
  localparam int HW = $clog2(PULSE_LEN + 2) + 1;

  function automatic logic [CNT_W-1:0] lim_f(input logic [SEL_W-1:0] s);
    logic [CNT_W:0] one;
    one = (CNT_W+1)'(1);
    return CNT_W'((one << (BASE_LOG2 + int'(s))) - (CNT_W+1)'(1));
  endfunction

  logic [HW-1:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_len <= '0;
    else if (cpu_rst_o) hi_len <= hi_len + HW'(1);
    else                hi_len <= '0;
  end

  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o <= lim_f(sel_rd_i));

  p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_rd_i |-> cnt_o == '0);

  p_restart_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && restart_wr_i && !pwr_down_i && !cpu_rst_o) |=> cnt_o == '0);

  p_pd_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down_i |=> (!en_rd_i && cnt_o == '0));

  p_rise_at_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_o) |-> ($past(tick_i) && $past(cnt_o) == lim_f($past(sel_rd_i))));

  p_pulse_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_rst_o) |-> hi_len == HW'(PULSE_LEN));

  p_ctrl_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_rst_o) |-> (!en_rd_i && sel_rd_i == '0));

  p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rd_i && !cfg_we_i && !pwr_down_i && !cpu_rst_o && tick_i && cnt_o != lim_f(sel_rd_i))
      |=> cnt_o == $past(cnt_o) + CNT_W'(1));
endmodule

bind wdog_timer wdog_timer_chk #(
  .SEL_W     (SEL_W),
  .BASE_LOG2 (BASE_LOG2),
  .PULSE_LEN (PULSE_LEN),
  .CNT_W     (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_i       (tick_i),
  .pwr_down_i   (pwr_down_i),
  .cfg_we_i     (cfg_we_i),
  .restart_wr_i (cfg_wdata_i[wdog_pkg::RESTART_BIT]),
  .en_rd_i      (cfg_rdata_o[wdog_pkg::EN_BIT]),
  .sel_rd_i     (cfg_rdata_o[wdog_pkg::SEL_LSB +: SEL_W]),
  .cnt_o        (cnt_o),
  .cpu_rst_o    (cpu_rst_o)
);

// File: tb/wdog_timer_test.sv
module wdog_timer_test;
  logic        clk;
  logic        rst_n;
  logic        tick_i;
  logic        pwr_down_i;
  logic        cfg_we_i;
  logic [4:0]  cfg_wdata_i;
  logic [4:0]  cfg_rdata_o;
  logic [11:0] cnt_o;
  logic        cpu_rst_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // table entries: {select, expected period in ticks}
  localparam logic [14:0] VEC [4] = '{
    {3'd0, 12'd16}, {3'd1, 12'd32}, {3'd4, 12'd256}, {3'd7, 12'd2048}
  };

  wdog_timer uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .pwr_down_i  (pwr_down_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .cnt_o       (cnt_o),
    .cpu_rst_o   (cpu_rst_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input bit en, input bit rs, input int sel);
    cfg_we_i    = 1'b1;
    cfg_wdata_i = {3'(sel), rs, en};
    step();
    cfg_we_i    = 1'b0;
    cfg_wdata_i = '0;
  endtask

  task automatic ticks(input int n);
    tick_i = 1'b1;
    repeat (n) step();
    tick_i = 1'b0;
  endtask

  task automatic drain_pulse(input string tag);
    for (int k = 0; k < 3; k++) begin
      step();
      chk({tag, " pulse held"}, cpu_rst_o, 1);
    end
    step();
    chk({tag, " pulse ended"}, cpu_rst_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_i = 1'b0; pwr_down_i = 1'b0;
    cfg_we_i = 1'b0; cfg_wdata_i = '0;
    repeat (3) step();
    chk("R1 rdata in reset", cfg_rdata_o, 0);
    chk("R1 cnt in reset", cnt_o, 0);
    chk("R1 cpu_rst in reset", cpu_rst_o, 0);
    rst_n = 1'b1;
    repeat (3) step();
    chk("R1 rdata after release", cfg_rdata_o, 0);
    chk("R1 cnt after release", cnt_o, 0);

    // table walk over period selects (R2, R7, R8, R9)
    for (int v = 0; v < 4; v++) begin
      int sel = int'(VEC[v][14:12]);
      int per = int'(VEC[v][11:0]);
      wr(1, 0, sel);
      chk("R2 rdata after arm", cfg_rdata_o, (sel << 2) | 1);
      ticks(per - 1);
      chk("R9 cnt one before limit", cnt_o, per - 1);
      chk("R2 no pulse before limit", cpu_rst_o, 0);
      ticks(1);
      chk("R7 pulse after final tick", cpu_rst_o, 1);
      chk("R7 cnt cleared at timeout", cnt_o, 0);
      drain_pulse("R7");
      chk("R8 ctrl cleared after pulse", cfg_rdata_o, 0);
    end

    // R9: hold without ticks, count on ticks only
    wr(1, 0, 0);
    repeat (3) step();
    chk("R9 hold without tick", cnt_o, 0);
    for (int k = 0; k < 6; k++) begin
      tick_i = (k % 2 == 0);
      step();
    end
    tick_i = 1'b0;
    chk("R9 alternating ticks", cnt_o, 3);

    // R4: restart clears count and reads back 0
    ticks(7);
    chk("R9 cnt before restart", cnt_o, 10);
    wr(1, 1, 0);
    chk("R4 restart clears cnt", cnt_o, 0);
    chk("R4 restart bit reads 0", cfg_rdata_o, 1);
    ticks(15);
    chk("R4 full period after restart", cpu_rst_o, 0);
    chk("R4 cnt after restart", cnt_o, 15);
    ticks(1);
    chk("R4 timeout after restart", cpu_rst_o, 1);
    // R7: write during pulse ignored
    wr(1, 0, 3);
    step(); step();
    step();
    chk("R7 pulse ended after write", cpu_rst_o, 0);
    chk("R7 write in pulse ignored", cfg_rdata_o, 0);

    // R5: select change clears, same write keeps
    wr(1, 0, 0);
    ticks(5);
    chk("R5 cnt before change", cnt_o, 5);
    wr(1, 0, 1);
    chk("R5 select change clears", cnt_o, 0);
    chk("R5 rdata new select", cfg_rdata_o, 5);
    ticks(4);
    wr(1, 0, 1);
    chk("R5 same write keeps cnt", cnt_o, 4);

    // R3: disable
    wr(0, 0, 1);
    chk("R3 disable clears cnt", cnt_o, 0);
    chk("R3 rdata disabled", cfg_rdata_o, 4);
    ticks(40);
    chk("R3 ticks ignored", cnt_o, 0);
    chk("R3 no pulse when disabled", cpu_rst_o, 0);

    // R6: power-down
    wr(1, 0, 0);
    ticks(5);
    pwr_down_i = 1'b1;
    step();
    chk("R6 enable forced off", cfg_rdata_o, 0);
    chk("R6 cnt cleared", cnt_o, 0);
    wr(1, 0, 0);
    chk("R6 write ignored", cfg_rdata_o, 0);
    ticks(20);
    chk("R6 ticks ignored", cnt_o, 0);
    chk("R6 no pulse", cpu_rst_o, 0);
    pwr_down_i = 1'b0;
    step();

    // R1: asynchronous reset mid-count
    wr(1, 0, 2);
    ticks(9);
    chk("R1 cnt before async reset", cnt_o, 9);
    #1 rst_n = 1'b0;
    #1;
    chk("R1 async reset cnt", cnt_o, 0);
    chk("R1 async reset rdata", cfg_rdata_o, 0);
    step();
    rst_n = 1'b1;
    repeat (3) step();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule